// File: doc/BRIEF.md
# Electronic Exposure Shutter Controller

This block sets a sensor's exposure time one field at a time. It decides, for every field, whether substrate-discharge (SUB) pulses are issued and how many. It takes these settings from the register block:

- a 2-bit shutter mode;
- a vertical-period count, which is the number of extra fields in a long exposure;
- a horizontal-period count, which gives the number of discharge pulses;
- a placement index, which picks the field of a long exposure that carries the pulses.

A field begins with a one-cycle VD-fall strobe. Every line after that begins with a one-cycle HD-fall strobe. Line indices count HD falls since the last VD fall, so the first line after VD is line 1. A field is assumed to span `LINES` lines, with the readout at the next VD fall. A burst of N pulses therefore occupies the last N lines before readout: lines `LINES-N` to `LINES-1`. Each pulse is a one-cycle request on `sub_req`. The analog stage positions the pulse within its line.

A long exposure spans several fields. While it runs, the block raises `hold_regs` and ignores new register values. A suppression mode withholds the readout for one field, so the exposure extends into the next field. Every setting is sampled only at a VD fall.

Top module: `exposure_shutter`

## Requirements
- R1: After reset `sub_req`, `hold_regs` and `readout_suppress` are all 0, and no pulse is issued before the first VD fall.
- R2: Mode code 00 (stopped) issues no SUB pulses in the field.
- R3: In modes 01 and 10, a pulse-carrying field gets N = (horizontal count + 1) pulses, one per line, on lines `LINES-N` to `LINES-1`.
- R4: When `a_field` is 1 at the VD fall, N = horizontal count - 1 for that field, floored at 0.
- R5: Bit 11 of `cfg_hcnt` is ignored; only bits 10:0 form the horizontal count.
- R6: N is capped at `LINES-1`.
- R7: In mode 01 with vertical count V > 0, the exposure spans V+1 fields, numbered 0 to V. Only field V carries pulses. `hold_regs` is 1 in fields 0 to V-1 and 0 in field V.
- R8: While `hold_regs` is 1, register values presented at a VD fall are ignored.
- R9: In mode 10, only the field whose index equals the placement index carries pulses. A placement index greater than V gives no pulses in any field.
- R10: Mode code 11 raises `readout_suppress` for that field, ignores all shutter counts and issues no pulses. `readout_suppress` changes only on the clock edge that samples a VD fall.
- R11: A change of register values in mid-field has no effect until the next VD fall.
- R12: Each `sub_req` is one cycle long and comes in the cycle after an HD fall that is not also a VD fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vd_fall | input | 1 | One-cycle field-start strobe |
| hd_fall | input | 1 | One-cycle line-start strobe |
| a_field | input | 1 | Frame-mode A field flag, sampled at VD fall |
| cfg_mode | input | 2 | 00 stop, 01 run, 10 placed, 11 suppress |
| cfg_vcnt | input | 10 | Vertical-period count V |
| cfg_hcnt | input | 12 | Horizontal-period count (bit 11 ignored) |
| cfg_place | input | 10 | Field index that carries the burst in mode 10 |
| sub_req | output | 1 | Per-line SUB pulse request |
| hold_regs | output | 1 | Register updates held off |
| readout_suppress | output | 1 | Withhold readout pulses this field |

## Verification
`hold_regs` and `readout_suppress` take their new values on the clock edge that samples a VD fall. The bench reads them at the falling edge that follows. Each `sub_req` is due exactly one cycle after its HD fall. The monitor samples at falling edges and uses the line number of the HD fall it saw in the previous cycle to check where the pulse landed. Pulse counts are compared field by field: the driver queues the expected count for each field, and the monitor pops and compares that entry at the VD fall that ends the field. At least two idle cycles follow the last line of each field, so its final request is counted before the compare.

// File: rtl/shutter_pkg.sv
package shutter_pkg;

    typedef enum logic [1:0] {
        MODE_STOP     = 2'b00,
        MODE_RUN      = 2'b01,
        MODE_PLACE    = 2'b10,
        MODE_SUPPRESS = 2'b11
    } shut_mode_e;

    typedef enum logic [2:0] {
        ST_STOP,
        ST_SUPPRESS,
        ST_SINGLE,
        ST_LONG,
        ST_LONG_END
    } shut_state_e;

endpackage

// File: rtl/shutter_seq.sv
module shutter_seq
    import shutter_pkg::*;
#(
    parameter int VW = 10,
    parameter int HW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vd_fall,
    input  logic          a_field,
    input  logic [1:0]    cfg_mode,
    input  logic [VW-1:0] cfg_vcnt,
    input  logic [HW-1:0] cfg_hcnt,
    input  logic [VW-1:0] cfg_place,
    output logic [HW-2:0] hcnt_o,
    output logic          afield_o,
    output logic          burst_o,
    output logic          hold_o,
    output logic          supp_o
);

    shut_state_e   state_q, state_d, entry_state;
    shut_mode_e    mode_q;
    logic [VW-1:0] vcnt_q, place_q, fidx_q, fidx_inc, target;
    logic [HW-2:0] hcnt_q;
    logic          afield_q;
    logic          accept;

    assign fidx_inc = fidx_q + VW'(1);
    assign accept   = (state_q != ST_LONG);

    // State a new register set starts in.
    always_comb begin
        unique case (shut_mode_e'(cfg_mode))
            MODE_STOP:     entry_state = ST_STOP;
            MODE_SUPPRESS: entry_state = ST_SUPPRESS;
            MODE_RUN,
            MODE_PLACE:    entry_state = (cfg_vcnt == '0) ? ST_SINGLE : ST_LONG;
            default:       entry_state = ST_STOP;
        endcase
    end

    // Transitions, taken only at a VD fall.
    always_comb begin
        state_d = state_q;
        if (vd_fall) begin
            unique case (state_q)
                ST_LONG:     state_d = (fidx_inc == vcnt_q) ? ST_LONG_END : ST_LONG;
                ST_STOP,
                ST_SUPPRESS,
                ST_SINGLE,
                ST_LONG_END: state_d = entry_state;
                default:     state_d = ST_STOP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // Settings captured at VD fall, plus the field index.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MODE_STOP;
            vcnt_q   <= '0;
            place_q  <= '0;
            hcnt_q   <= '0;
            fidx_q   <= '0;
            afield_q <= 1'b0;
        end else if (vd_fall) begin
            afield_q <= a_field;
            if (accept) begin
                mode_q  <= shut_mode_e'(cfg_mode);
                vcnt_q  <= cfg_vcnt;
                place_q <= cfg_place;
                hcnt_q  <= cfg_hcnt[HW-2:0];
                fidx_q  <= '0;
            end else begin
                fidx_q  <= fidx_inc;
            end
        end
    end

    assign target = (mode_q == MODE_PLACE) ? place_q : vcnt_q;

    // Outputs decoded from the state.
    always_comb begin
        hold_o  = 1'b0;
        supp_o  = 1'b0;
        burst_o = 1'b0;
        unique case (state_q)
            ST_STOP:     ;
            ST_SUPPRESS: supp_o = 1'b1;
            ST_SINGLE:   burst_o = (fidx_q == target);
            ST_LONG: begin
                hold_o  = 1'b1;
                burst_o = (fidx_q == target);
            end
            ST_LONG_END: burst_o = (fidx_q == target);
            default:     ;
        endcase
    end

    assign hcnt_o   = hcnt_q;
    assign afield_o = afield_q;

endmodule

// File: rtl/shutter_count.sv
module shutter_count #(
    parameter int HW    = 12,
    parameter int LINES = 32,
    localparam int NW   = $clog2(LINES)
) (
    input  logic [HW-2:0] hval,
    input  logic          afield,
    output logic [NW-1:0] npulse
);

    logic [HW-1:0] raw;
    logic [HW-1:0] cap;

    assign cap = HW'(LINES - 1);

    always_comb begin
        if (afield) raw = (hval == '0) ? '0 : ({1'b0, hval} - HW'(1));
        else        raw = {1'b0, hval} + HW'(1);
    end

    assign npulse = (raw > cap) ? NW'(LINES - 1) : raw[NW-1:0];

endmodule

// File: rtl/shutter_line.sv
module shutter_line #(
    parameter int LINES = 32,
    localparam int NW   = $clog2(LINES),
    localparam int LW   = $clog2(LINES) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vd_fall,
    input  logic          hd_fall,
    input  logic          burst,
    input  logic [NW-1:0] npulse,
    output logic          sub_req
);

    logic [LW-1:0] line_q, line_nx, first_line;
    logic          in_window;

    assign line_nx    = (line_q == '1) ? line_q : line_q + LW'(1);
    assign first_line = LW'(LINES) - LW'(npulse);
    assign in_window  = (line_nx >= first_line) && (line_nx <= LW'(LINES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q  <= '0;
            sub_req <= 1'b0;
        end else if (vd_fall) begin
            line_q  <= '0;
            sub_req <= 1'b0;
        end else if (hd_fall) begin
            line_q  <= line_nx;
            sub_req <= burst && in_window;
        end else begin
            sub_req <= 1'b0;
        end
    end

endmodule

// File: rtl/exposure_shutter.sv
module exposure_shutter #(
    parameter int VW    = 10,
    parameter int HW    = 12,
    parameter int LINES = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vd_fall,
    input  logic          hd_fall,
    input  logic          a_field,
    input  logic [1:0]    cfg_mode,
    input  logic [VW-1:0] cfg_vcnt,
    input  logic [HW-1:0] cfg_hcnt,
    input  logic [VW-1:0] cfg_place,
    output logic          sub_req,
    output logic          hold_regs,
    output logic          readout_suppress
);

    localparam int NW = $clog2(LINES);

    logic [HW-2:0] hcnt_act;
    logic          afield_act;
    logic          burst;
    logic [NW-1:0] npulse;

    shutter_seq #(.VW(VW), .HW(HW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .vd_fall  (vd_fall),
        .a_field  (a_field),
        .cfg_mode (cfg_mode),
        .cfg_vcnt (cfg_vcnt),
        .cfg_hcnt (cfg_hcnt),
        .cfg_place(cfg_place),
        .hcnt_o   (hcnt_act),
        .afield_o (afield_act),
        .burst_o  (burst),
        .hold_o   (hold_regs),
        .supp_o   (readout_suppress)
    );

    shutter_count #(.HW(HW), .LINES(LINES)) u_cnt (
        .hval  (hcnt_act),
        .afield(afield_act),
        .npulse(npulse)
    );

    shutter_line #(.LINES(LINES)) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .vd_fall(vd_fall),
        .hd_fall(hd_fall),
        .burst  (burst),
        .npulse (npulse),
        .sub_req(sub_req)
    );

endmodule

// File: rtl/exposure_shutter_chk.sv
module exposure_shutter_chk (
    input logic clk,
    input logic rst_n,
    input logic vd_fall,
    input logic hd_fall,
    input logic sub_req,
    input logic hold_regs,
    input logic readout_suppress
);

    a_r12_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sub_req |=> !sub_req);

    a_r12_after_hd: assert property (@(posedge clk) disable iff (!rst_n)
        sub_req |-> ($past(hd_fall) && !$past(vd_fall)));

    a_r10_supp_no_sub: assert property (@(posedge clk) disable iff (!rst_n)
        readout_suppress |-> !sub_req);

    a_r10_supp_at_vd: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(readout_suppress) |-> $past(vd_fall));

    a_r7_hold_at_vd: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hold_regs) |-> $past(vd_fall));

    a_r8_hold_excl_supp: assert property (@(posedge clk) disable iff (!rst_n)
        hold_regs |-> !readout_suppress);

endmodule

bind exposure_shutter exposure_shutter_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .vd_fall         (vd_fall),
    .hd_fall         (hd_fall),
    .sub_req         (sub_req),
    .hold_regs       (hold_regs),
    .readout_suppress(readout_suppress)
);

// File: tb/sim_exposure_shutter.sv
`timescale 1ns/1ps
module sim_exposure_shutter;

    localparam int LINES = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vd_fall = 1'b0, hd_fall = 1'b0, a_field = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic [9:0]  cfg_vcnt = '0, cfg_place = '0;
    logic [11:0] cfg_hcnt = '0;
    logic        sub_req, hold_regs, readout_suppress;

    int n_chk = 0, n_fail = 0;
    int exp_q[$];
    string tag_q[$];
    int pulse_cnt = 0;
    int cur_line = 0;
    logic prev_hd = 1'b0;
    bit done = 0;

    always #2.5 clk = ~clk;

    exposure_shutter u0 (
        .clk(clk), .rst_n(rst_n), .vd_fall(vd_fall), .hd_fall(hd_fall),
        .a_field(a_field), .cfg_mode(cfg_mode), .cfg_vcnt(cfg_vcnt),
        .cfg_hcnt(cfg_hcnt), .cfg_place(cfg_place), .sub_req(sub_req),
        .hold_regs(hold_regs), .readout_suppress(readout_suppress)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: per-pulse timing/position, and per-field count from the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sub_req) begin
                pulse_cnt++;
                check(prev_hd && (exp_q.size() == 0 || cur_line >= LINES - exp_q[0]),
                      "R12/R3 pulse after HD on last lines", cur_line,
                      (exp_q.size() > 0) ? LINES - exp_q[0] : 0);
            end
            if (vd_fall) begin
                if (exp_q.size() > 0) begin
                    int e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(pulse_cnt == e, t, pulse_cnt, e);
                end
                pulse_cnt = 0;
            end
            prev_hd = hd_fall;
        end
    end

    // Driver: one field; optional mid-field write of cfg_hcnt (R11).
    task automatic field(input int exp, input bit exp_hold, input bit exp_supp,
                         input string tag, input int mid_hcnt);
        @(posedge clk); #1 vd_fall = 1'b1; cur_line = 0;
        @(posedge clk); #1 vd_fall = 1'b0;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        check(hold_regs == exp_hold, {tag, " hold"}, hold_regs, exp_hold);
        check(readout_suppress == exp_supp, {tag, " suppress"}, readout_suppress, exp_supp);
        for (int l = 1; l < LINES; l++) begin
            @(posedge clk); #1 hd_fall = 1'b1; cur_line = l;
            @(posedge clk); #1 hd_fall = 1'b0;
            if (l == 3 && mid_hcnt >= 0) cfg_hcnt = 12'(mid_hcnt);
            repeat (2) @(posedge clk);
        end
        repeat (2) @(posedge clk);
    endtask

    task automatic setcfg(input logic [1:0] m, input int v, input int h, input int p);
        cfg_mode = m; cfg_vcnt = 10'(v); cfg_hcnt = 12'(h); cfg_place = 10'(p);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(sub_req == 0, "R1 sub_req", sub_req, 0);
        check(hold_regs == 0, "R1 hold", hold_regs, 0);
        check(readout_suppress == 0, "R1 suppress", readout_suppress, 0);
        // R1: HD falls before any VD fall give no pulse
        for (int l = 0; l < 4; l++) begin
            @(posedge clk); #1 hd_fall = 1'b1;
            @(posedge clk); #1 hd_fall = 1'b0;
            @(negedge clk);
            check(sub_req == 0, "R1 no pulse before VD", sub_req, 0);
        end

        setcfg(2'b00, 0, 5, 0);   field(0, 0, 0, "R2 stopped", -1);
        setcfg(2'b01, 0, 4, 0);   field(5, 0, 0, "R3 hcnt+1", -1);
        setcfg(2'b01, 0, 9, 0);   field(10, 0, 0, "R3 hcnt+1 wider", -1);
        a_field = 1'b1;
        setcfg(2'b01, 0, 4, 0);   field(3, 0, 0, "R4 A field", -1);
        setcfg(2'b01, 0, 0, 0);   field(0, 0, 0, "R4 A field floor", -1);
        setcfg(2'b01, 0, 1, 0);   field(0, 0, 0, "R4 A field one", -1);
        a_field = 1'b0;
        setcfg(2'b01, 0, 12'h805, 0); field(6, 0, 0, "R5 top bit ignored", -1);
        setcfg(2'b01, 0, 100, 0); field(31, 0, 0, "R6 cap", -1);
        setcfg(2'b01, 0, 2, 0);   field(3, 0, 0, "R11 mid-field write", 7);
        setcfg(2'b01, 0, 1, 0);   field(2, 0, 0, "R11 applied at next VD", -1);

        // R7/R8: long exposure, V=2
        setcfg(2'b01, 2, 3, 0);   field(0, 1, 0, "R7 long field0", -1);
        setcfg(2'b00, 0, 9, 0);   field(0, 1, 0, "R8 held field1", -1);
        field(4, 0, 0, "R7 long last field", -1);
        field(0, 0, 0, "R8 new data after release", -1);

        // R9: placed burst
        setcfg(2'b10, 2, 2, 1);   field(0, 1, 0, "R9 field0", -1);
        field(3, 1, 0, "R9 placed field1", -1);
        field(0, 0, 0, "R9 field2", -1);
        setcfg(2'b10, 0, 1, 0);   field(2, 0, 0, "R9 single placed", -1);
        setcfg(2'b10, 1, 1, 3);   field(0, 1, 0, "R9 out of range f0", -1);
        field(0, 0, 0, "R9 out of range f1", -1);

        // R10: suppression
        setcfg(2'b11, 0, 7, 0);   field(0, 0, 1, "R10 suppress", -1);
        setcfg(2'b01, 0, 0, 0);   field(1, 0, 0, "R10 after suppress", -1);

        // flush last field
        @(posedge clk); #1 vd_fall = 1'b1;
        @(posedge clk); #1 vd_fall = 1'b0;
        repeat (3) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule